// File: doc/BRIEF.md
# Narrow Host Bus to Quadlet Register Bridge

This block lets an 8-bit or 16-bit microprocessor bus reach a bank of 32-bit registers. Because every register is a full quadlet, a narrow write only lands in a holding register. The register itself is written once the piece that completes the quadlet arrives. A narrow read works the other way round. The piece that opens a quadlet takes a snapshot of the whole register, and the snapshot then returns the remaining pieces.

Byte and bit numbering is big-endian: byte 0 is the most significant. The handshake on the active-low ready line follows one of four policies. Both the policy and the bus width are sampled while reset is held. Each bus cycle starts when chip select is seen low after being high. Ready appears after a latency that depends on where the piece sits in the quadlet: short for pieces that only touch the holding or snapshot register, long for pieces that reach the register bank.

Top module: `narrow_reg_bridge`

## Requirements
- R1: `mode_sel` (00 acknowledge every cycle, 01 acknowledge on quadlet boundary, 10 silent, 11 blind) and `wide_sel` (1 = 16-bit bus, 0 = 8-bit bus) are captured only while `rst_n` is low. Changing them afterwards has no effect.
- R2: After reset `rdy_n` is high and no register access is issued. A bus cycle begins at the first clock edge that sees `cs_n` low after it was high.
- R3: A write piece is collected in a holding register. The bank is written (`reg_we`) only for the final piece, with the full merged quadlet. The final piece is byte offset 3 on the 8-bit bus, or `addr[1]`=1 on the 16-bit bus. Earlier pieces leave the bank unchanged.
- R4: Lanes are big-endian. On the 8-bit bus, byte offset 0 maps to bits 31:24 and offset 3 to bits 7:0, with data on `wdata[7:0]`/`rdata[7:0]` and the upper read byte zero. On the 16-bit bus, `addr[1]`=0 maps to bits 31:16.
- R5: A read of the first piece (offset 0, or `addr[1]`=0 on the 16-bit bus) snapshots the register (`reg_re`). Later pieces return data from that snapshot even if the bank changed in between.
- R6: In mode 00 every cycle is acknowledged. `rdy_n` goes low and stays low while `cs_n` is low, and returns high at the first edge that sees `cs_n` high.
- R7: Ready latency is the number of clock edges after the start edge. It is 5 for a non-final write piece, 17 for a final write piece, 17 for a first read piece and 5 for any later read piece.
- R8: In mode 01 only the final write piece and the first read piece are acknowledged, with the R7 latency. Read data is still valid after the R7 latency for unacknowledged pieces.
- R9: In modes 10 and 11 `rdy_n` never goes low. The data path still behaves as in R3–R5.
- R10: If `cs_n` returns high before or at the edge where the latency expires, no ready is given. The piece's effect on the holding register, the snapshot or the bank still stands.
- R11: The register index is `addr[8:2]`, so the 9-bit byte address covers 128 quadlets (512 bytes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; mode and width sampled while low |
| mode_sel | input | 2 | Handshake policy select |
| wide_sel | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| cs_n | input | 1 | Active-low chip select, framing one bus cycle |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 9 | Host byte address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| rdy_n | output | 1 | Active-low ready acknowledge |
| reg_we | output | 1 | Register bank write strobe |
| reg_re | output | 1 | Register bank snapshot strobe |
| reg_addr | output | 7 | Register bank quadlet index |
| reg_wdata | output | 32 | Quadlet written to the bank |
| reg_rdata | input | 32 | Quadlet read from the bank |

## Verification
Latency expiry and the host releasing chip select can fall on the same clock edge. The bench provokes this by holding `cs_n` low for exactly the latency count, so that its rise is sampled at the expiry edge. It expects ready to stay high while the write still commits or the snapshot is still taken. One edge later, ready must assert and be held. Bank updates done by the bench between two read pieces fall in the same window as a pending snapshot. The later pieces must still return the older quadlet.

// File: rtl/hbb_pkg.sv
`timescale 1ns/1ps
package hbb_pkg;
   typedef enum logic [1:0] {
      HS_EACH  = 2'b00,
      HS_QUAD  = 2'b01,
      HS_NONE  = 2'b10,
      HS_BLIND = 2'b11
   } hs_mode_e;

   typedef enum logic [1:0] {
      ST_ARM  = 2'b00,
      ST_IDLE = 2'b01,
      ST_BUSY = 2'b10
   } cyc_st_e;
endpackage

// File: rtl/hbb_lane_map.sv
`timescale 1ns/1ps
// Big-endian placement of a narrow piece inside a quadlet, both ways.
module hbb_lane_map #(
   parameter int REG_W = 32,
   parameter int BUS_W = 16
) (
   input  logic             wide,
   input  logic [1:0]       off,
   input  logic [REG_W-1:0] quad_in,
   input  logic [BUS_W-1:0] piece_in,
   output logic [REG_W-1:0] quad_out,
   output logic [BUS_W-1:0] piece_out
);
   localparam int NB = REG_W / 8;

   if (REG_W != 32) begin : g_chk_reg
      $error("hbb_lane_map: REG_W must be 32");
   end
   if (BUS_W != 16) begin : g_chk_bus
      $error("hbb_lane_map: BUS_W must be 16");
   end

   logic [7:0] lane [NB];

   for (genvar b = 0; b < NB; b++) begin : g_byte
      localparam logic [1:0] BI = 2'(b);
      localparam int         LO = REG_W - 8 * (b + 1);
      logic       hit;
      logic [7:0] src;
      assign hit = wide ? (off[1] == BI[1]) : (off == BI);
      assign src = (wide && !BI[0]) ? piece_in[15:8] : piece_in[7:0];
      assign quad_out[LO +: 8] = hit ? src : quad_in[LO +: 8];
      assign lane[b] = quad_in[LO +: 8];
   end

   always_comb begin
      if (wide) begin
         piece_out = off[1] ? {lane[2], lane[3]} : {lane[0], lane[1]};
      end else begin
         piece_out = {8'h00, lane[off]};
      end
   end
endmodule

// File: rtl/hbb_hs_timer.sv
`timescale 1ns/1ps
// Bus cycle framing and ready latency counter.
module hbb_hs_timer
   import hbb_pkg::*;
#(
   parameter int LAT_FAST = 5,
   parameter int LAT_SLOW = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic ack_en,
   input  logic slow,
   output logic start,
   output logic done,
   output logic rdy_n
);
   localparam int CNT_W = $clog2(LAT_SLOW + 1);
   localparam logic [CNT_W-1:0] C_FAST = CNT_W'(LAT_FAST);
   localparam logic [CNT_W-1:0] C_SLOW = CNT_W'(LAT_SLOW);

   if (LAT_FAST < 1 || LAT_SLOW < LAT_FAST) begin : g_chk_lat
      $error("hbb_hs_timer: need 1 <= LAT_FAST <= LAT_SLOW");
   end

   cyc_st_e          st;
   logic [CNT_W-1:0] cnt;
   logic             ack_q;

   assign start = (st == ST_IDLE) && !cs_n;
   assign done  = (st == ST_BUSY) && !cs_n && (cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_ARM;
         cnt   <= '0;
         ack_q <= 1'b0;
         rdy_n <= 1'b1;
      end else begin
         unique case (st)
            ST_ARM: begin
               if (cs_n) begin
                  st    <= ST_IDLE;
                  rdy_n <= 1'b1;
               end
            end
            ST_IDLE: begin
               if (!cs_n) begin
                  st    <= ST_BUSY;
                  cnt   <= slow ? C_SLOW : C_FAST;
                  ack_q <= ack_en;
               end
            end
            ST_BUSY: begin
               if (cs_n) begin
                  st <= ST_IDLE;
               end else if (cnt == CNT_W'(1)) begin
                  st    <= ST_ARM;
                  rdy_n <= !ack_q;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= ST_ARM;
         endcase
      end
   end
endmodule

// File: rtl/narrow_reg_bridge.sv
`timescale 1ns/1ps
module narrow_reg_bridge
   import hbb_pkg::*;
#(
   parameter int ADDR_W   = 9,
   parameter int BUS_W    = 16,
   parameter int REG_W    = 32,
   parameter int LAT_FAST = 5,
   parameter int LAT_SLOW = 17
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  mode_sel,
   input  logic                        wide_sel,
   input  logic                        cs_n,
   input  logic                        rd_wr_n,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [BUS_W-1:0]            wdata,
   output logic [BUS_W-1:0]            rdata,
   output logic                        rdy_n,
   output logic                        reg_we,
   output logic                        reg_re,
   output logic [ADDR_W-3:0]           reg_addr,
   output logic [REG_W-1:0]            reg_wdata,
   input  logic [REG_W-1:0]            reg_rdata
);
   localparam int RA_W = ADDR_W - 2;

   if (ADDR_W < 3) begin : g_chk_addr
      $error("narrow_reg_bridge: ADDR_W must be at least 3");
   end

   hs_mode_e         mode_q;
   logic             wide_q;
   logic [1:0]       off;
   logic             first_pc;
   logic             last_pc;
   logic             ack_en;
   logic             slow;
   logic             start;
   logic             done;
   logic [REG_W-1:0] hold_q;
   logic [REG_W-1:0] snap_q;
   logic [REG_W-1:0] merged;
   logic [BUS_W-1:0] piece_unused;
   logic [BUS_W-1:0] rd_piece;
   logic [1:0]       off_q;
   logic             rd_q;

   // Policy and width are taken only while reset is held.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= hs_mode_e'(mode_sel);
         wide_q <= wide_sel;
      end
   end

   assign off      = addr[1:0];
   assign first_pc = wide_q ? !off[1] : (off == 2'd0);
   assign last_pc  = wide_q ?  off[1] : (off == 2'd3);
   assign slow     = rd_wr_n ? first_pc : last_pc;

   always_comb begin
      unique case (mode_q)
         HS_EACH: ack_en = 1'b1;
         HS_QUAD: ack_en = rd_wr_n ? first_pc : last_pc;
         default: ack_en = 1'b0;
      endcase
   end

   hbb_hs_timer #(
      .LAT_FAST (LAT_FAST),
      .LAT_SLOW (LAT_SLOW)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_n   (cs_n),
      .ack_en (ack_en),
      .slow   (slow),
      .start  (start),
      .done   (done),
      .rdy_n  (rdy_n)
   );

   // Write side: place the incoming piece into the holding quadlet.
   hbb_lane_map #(
      .REG_W (REG_W),
      .BUS_W (BUS_W)
   ) u_wr_map (
      .wide      (wide_q),
      .off       (off),
      .quad_in   (hold_q),
      .piece_in  (wdata),
      .quad_out  (merged),
      .piece_out (piece_unused)
   );

   // Read side: pick the latched piece out of the snapshot.
   hbb_lane_map #(
      .REG_W (REG_W),
      .BUS_W (BUS_W)
   ) u_rd_map (
      .wide      (wide_q),
      .off       (off_q),
      .quad_in   (snap_q),
      .piece_in  ('0),
      .quad_out  (),
      .piece_out (rd_piece)
   );

   assign reg_addr  = addr[ADDR_W-1:2];
   assign reg_wdata = merged;
   assign reg_we    = start && !rd_wr_n && last_pc;
   assign reg_re    = start &&  rd_wr_n && first_pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         snap_q <= '0;
         off_q  <= '0;
         rd_q   <= 1'b0;
         rdata  <= '0;
      end else begin
         if (start) begin
            off_q <= off;
            rd_q  <= rd_wr_n;
            if (!rd_wr_n) begin
               hold_q <= merged;
            end
         end
         if (reg_re) begin
            snap_q <= reg_rdata;
         end
         if (done && rd_q) begin
            rdata <= rd_piece;
         end
      end
   end

   logic unused_ok;
   assign unused_ok = ^{piece_unused, RA_W[0]};
endmodule

// File: rtl/hbb_chk.sv
`timescale 1ns/1ps
module hbb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       rd_wr_n,
   input logic       rdy_n,
   input logic       reg_we,
   input logic       reg_re,
   input logic [1:0] mode_q
);
   AST_MODE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mode_q)); // R1

   AST_WE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (!rd_wr_n && !cs_n)); // R3

   AST_RE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> (rd_wr_n && !cs_n)); // R5

   AST_RDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !cs_n) |=> !rdy_n); // R6

   AST_RDY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdy_n) |-> $past(!cs_n)); // R10

   AST_SILENT_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[1] |-> rdy_n); // R9
endmodule

bind narrow_reg_bridge hbb_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .rd_wr_n (rd_wr_n),
   .rdy_n   (rdy_n),
   .reg_we  (reg_we),
   .reg_re  (reg_re),
   .mode_q  (mode_q)
);

// File: tb/narrow_reg_bridge_bench.sv
`timescale 1ns/1ps
module narrow_reg_bridge_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_sel = 2'b00;
   logic        wide_sel = 1'b1;
   logic        cs_n = 1'b1;
   logic        rd_wr_n = 1'b1;
   logic [8:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        rdy_n;
   logic        reg_we;
   logic        reg_re;
   logic [6:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;

   logic        poke_en = 1'b0;
   logic [6:0]  poke_addr = '0;
   logic [31:0] poke_data = '0;
   logic [31:0] bank [128];

   int total = 0;
   int bad = 0;

   // model state
   logic [1:0]  cur_mode;
   logic        cur_wide;
   logic [31:0] exp_bank [128];
   logic [31:0] exp_hold;
   logic [31:0] exp_snap;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (poke_en) bank[poke_addr] <= poke_data;
      else if (reg_we) bank[reg_addr] <= reg_wdata;
   end
   assign reg_rdata = bank[reg_addr];

   narrow_reg_bridge u_narrow_reg_bridge (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .wide_sel  (wide_sel),
      .cs_n      (cs_n),
      .rd_wr_n   (rd_wr_n),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .rdy_n     (rdy_n),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] put_piece(logic [31:0] q, logic [1:0] off, logic wide, logic [15:0] d);
      logic [31:0] r = q;
      if (wide) begin
         if (off[1]) r[15:0] = d; else r[31:16] = d;
      end else begin
         r[31 - 8*off -: 8] = d[7:0];
      end
      return r;
   endfunction

   function automatic logic [15:0] get_piece(logic [31:0] q, logic [1:0] off, logic wide);
      if (wide) return off[1] ? q[15:0] : q[31:16];
      return {8'h00, q[31 - 8*off -: 8]};
   endfunction

   task automatic do_reset(input logic [1:0] m, input logic w);
      @(negedge clk);
      rst_n = 1'b0; cs_n = 1'b1; mode_sel = m; wide_sel = w;
      cur_mode = m; cur_wide = w;
      repeat (3) @(negedge clk);
      chk(rdy_n === 1'b1, "R2 rdy_n after reset", {31'd0, rdy_n}, 32'd1);
      chk(reg_we === 1'b0 && reg_re === 1'b0, "R2 no access in reset", {30'd0, reg_we, reg_re}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rdy_n === 1'b1, "R2 rdy_n idle", {31'd0, rdy_n}, 32'd1);
   endtask

   // hold_req = 0 picks the normal hold time; otherwise cs_n is held that many edges.
   task automatic access(input logic rd, input logic [8:0] a, input logic [15:0] wd,
                         input int hold_req, input string tag);
      logic [1:0] off = a[1:0];
      logic first = cur_wide ? !off[1] : (off == 2'd0);
      logic last  = cur_wide ?  off[1] : (off == 2'd3);
      logic ack;
      int   lat;
      int   hold;
      string rtag;
      case (cur_mode)
         2'b00: begin ack = 1'b1; rtag = "R6 R7 rdy_n"; end
         2'b01: begin ack = rd ? first : last; rtag = "R8 rdy_n"; end
         default: begin ack = 1'b0; rtag = "R9 rdy_n"; end
      endcase
      lat  = (rd ? first : last) ? 17 : 5;
      hold = (hold_req != 0) ? hold_req : (ack ? lat + 1 : lat + 2);
      if (hold_req != 0 && hold_req <= lat) begin
         ack  = 1'b0;
         rtag = "R10 rdy_n";
      end
      @(negedge clk);
      cs_n = 1'b0; rd_wr_n = rd; addr = a; wdata = wd;
      if (rd) begin
         if (first) exp_snap = bank[a[8:2]];
      end else begin
         exp_hold = put_piece(exp_hold, off, cur_wide, wd);
         if (last) exp_bank[a[8:2]] = exp_hold;
      end
      for (int k = 1; k <= hold; k++) begin
         @(negedge clk);
         chk(rdy_n === !(ack && (k - 1 >= lat)), {tag, " ", rtag}, {31'd0, rdy_n},
             {31'd0, !(ack && (k - 1 >= lat))});
         if (rd && k == hold && k - 1 >= lat)
            chk(rdata === get_piece(exp_snap, off, cur_wide), {tag, " R4 R5 rdata"},
                {16'd0, rdata}, {16'd0, get_piece(exp_snap, off, cur_wide)});
         if (k == hold) cs_n = 1'b1;
      end
      @(negedge clk);
      chk(rdy_n === 1'b1, {tag, " R6 release"}, {31'd0, rdy_n}, 32'd1);
      if (!rd)
         chk(bank[a[8:2]] === exp_bank[a[8:2]], {tag, " R3 R11 bank"},
             bank[a[8:2]], exp_bank[a[8:2]]);
   endtask

   task automatic poke(input logic [6:0] q, input logic [31:0] d);
      @(negedge clk);
      poke_en = 1'b1; poke_addr = q; poke_data = d;
      @(negedge clk);
      poke_en = 1'b0;
   endtask

   initial begin
      exp_hold = '0;
      // R1 R2: per-cycle handshake, 16-bit; later change of mode_sel ignored
      do_reset(2'b00, 1'b1);
      mode_sel = 2'b10;
      wide_sel = 1'b0;
      access(1'b0, 9'h010, 16'hA1B2, 0, "R1 R3 w16 half0");
      access(1'b0, 9'h012, 16'hC3D4, 0, "R3 R4 w16 half1");
      chk(bank[4] === 32'hA1B2C3D4, "R4 big-endian halves", bank[4], 32'hA1B2C3D4);
      access(1'b1, 9'h010, 16'h0, 0, "R7 r16 first");
      poke(7'd4, 32'h0);
      access(1'b1, 9'h012, 16'h0, 0, "R5 r16 snapshot");
      poke(7'd4, 32'hA1B2C3D4);

      // 8-bit bus, top quadlet, pieces out of order
      do_reset(2'b00, 1'b0);
      access(1'b0, 9'h1FE, 16'hFF33, 0, "R4 w8 off2");
      access(1'b0, 9'h1FC, 16'h0011, 0, "R4 w8 off0");
      access(1'b0, 9'h1FD, 16'h0022, 0, "R3 w8 off1");
      access(1'b0, 9'h1FF, 16'h0044, 0, "R11 w8 off3");
      chk(bank[127] === 32'h11223344, "R4 R11 byte order", bank[127], 32'h11223344);
      for (int b = 0; b < 4; b++)
         access(1'b1, 9'h1FC + 9'(b), 16'h0, 0, "R7 r8 byte");

      // R10: cs_n released exactly at latency expiry
      access(1'b0, 9'h020, 16'h0055, 5, "R10 abort w8 off0");
      access(1'b0, 9'h021, 16'h0066, 5, "R10 abort w8 off1");
      access(1'b0, 9'h022, 16'h0077, 6, "R10 w8 off2 just in time");
      access(1'b0, 9'h023, 16'h0088, 17, "R10 abort final commit");
      chk(bank[8] === 32'h55667788, "R10 effect kept", bank[8], 32'h55667788);
      access(1'b1, 9'h020, 16'h0, 17, "R10 abort snapshot");
      poke(7'd8, 32'h0);
      access(1'b1, 9'h023, 16'h0, 0, "R10 R5 snapshot kept");

      // R8: quadlet-boundary policy
      do_reset(2'b01, 1'b1);
      access(1'b0, 9'h030, 16'h1357, 0, "R8 w16 half0");
      access(1'b0, 9'h032, 16'h9BDF, 0, "R8 w16 half1");
      access(1'b1, 9'h030, 16'h0, 0, "R8 r16 half0");
      access(1'b1, 9'h032, 16'h0, 0, "R8 r16 half1");
      chk(bank[12] === 32'h13579BDF, "R8 data path", bank[12], 32'h13579BDF);

      // R9: silent policy, 8-bit
      do_reset(2'b10, 1'b0);
      for (int b = 0; b < 4; b++)
         access(1'b0, 9'h040 + 9'(b), 16'h00A0 + 16'(b), 0, "R9 silent w8");
      access(1'b1, 9'h040, 16'h0, 0, "R9 silent r8 first");
      access(1'b1, 9'h042, 16'h0, 0, "R9 silent r8 off2");

      // R9: blind policy, 16-bit
      do_reset(2'b11, 1'b1);
      access(1'b0, 9'h050, 16'hDEAD, 0, "R9 blind w16");
      access(1'b0, 9'h052, 16'hBEEF, 0, "R9 blind w16 final");
      access(1'b1, 9'h050, 16'h0, 0, "R9 blind r16");
      chk(bank[20] === 32'hDEADBEEF, "R9 blind data", bank[20], 32'hDEADBEEF);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog R2 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule